// File: doc/BRIEF.md
# SDRAM Precharge Timing Enforcer

This block guards the command spacing of one SDRAM bank. A memory controller presents its row-open (ACTIVE) and row-close (PRECHARGE) requests and reports every write data beat. The block holds back each spacing-limited command until the programmed minimum number of clocks has passed since the command it depends on. PRECHARGE waits for two things: the row has been open long enough, and the last write beat is far enough behind. ACTIVE waits until the previous PRECHARGE has had enough recovery time.

The three minimum spacings come from encoded fields of one 32-bit configuration register. The register has a fixed reset value. Bits outside the three fields always read as zero. The field codes that are marked reserved are clamped to the longest legal spacing of their field, so a wrong setting can only make the block slower, never unsafe. A command is accepted on a clock edge where its request and its ready are both high. The next dependent command may then be accepted no earlier than the N-th clock edge after that one, where N is the programmed spacing.

Top module: `sdram_spacing_guard`

## Requirements
- R1: After reset the register reads 0x0000_0142, and both `act_ready` and `pre_ready` are high.
- R2: Only bit 8, bits 6:4 and bits 1:0 are stored. All other bits read as zero, so writing all ones reads back 0x0000_0173.
- R3: Bit 8 sets the write-beat-to-PRECHARGE spacing. Value 0 gives 1 clock and value 1 gives 2 clocks.
- R4: Bits 6:4 set the ACTIVE-to-PRECHARGE spacing. Code c from 0 to 4 gives 4+c clocks.
- R5: Codes 5, 6 and 7 in bits 6:4 give the largest legal value, 8 clocks.
- R6: Bits 1:0 set the PRECHARGE-to-ACTIVE spacing. Codes 0, 1 and 2 give 2, 3 and 4 clocks.
- R7: Code 3 in bits 1:0 gives 4 clocks.
- R8: `pre_ready` is high only when both the ACTIVE-to-PRECHARGE spacing and the write-beat-to-PRECHARGE spacing have elapsed.
- R9: A register write applies only to commands accepted after the write. A spacing that is already running keeps the length it was loaded with.
- R10: If a command with spacing N is accepted at edge k, the dependent ready is low from edge k until edge k+N-1 and is high after edge k+N-1. As a result, the dependent command is first accepted at edge k+N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, with the bits that are not stored forced to zero |
| act_req | input | 1 | ACTIVE request |
| act_ready | output | 1 | ACTIVE may be accepted |
| wr_beat | input | 1 | A write data beat is issued this cycle |
| pre_req | input | 1 | PRECHARGE request |
| pre_ready | output | 1 | PRECHARGE may be accepted |

## Verification
The assertions assume that the controller never has an ACTIVE and a PRECHARGE accepted in the same cycle. They also assume that the register is not written while reset is held. The stimulus drives one request at a time and holds it for a single cycle, and only after the matching ready has been seen high. Register writes happen either while the bank is idle or in the middle of a running spacing, to check R9. The spacing checks open a measurement at the accepting edge and count clocks until the dependent ready rises. Each count is compared with the length that the bench decodes from the value it wrote.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  localparam int REG_W     = 32;
  localparam int DPL_BIT   = 8;
  localparam int RAS_LSB   = 4;
  localparam int RP_LSB    = 0;
  localparam logic [REG_W-1:0] RESET_VAL  = 32'h0000_0142;
  localparam logic [REG_W-1:0] STORE_MASK = 32'h0000_0173;

  // active-to-precharge: legal codes 0..4 -> 4..8 clocks, others clamp to 8
  function automatic int ras_clocks(input logic [2:0] code);
    return (code <= 3'd4) ? 4 + int'(code) : 8;
  endfunction

  // precharge-to-active: legal codes 0..2 -> 2..4 clocks, code 3 clamps to 4
  function automatic int rp_clocks(input logic [1:0] code);
    return (code <= 2'd2) ? 2 + int'(code) : 4;
  endfunction

  // last write beat to precharge: 1 or 2 clocks
  function automatic int dpl_clocks(input logic sel);
    return sel ? 2 : 1;
  endfunction
endpackage

// File: rtl/sdg_cfg_reg.sv
module sdg_cfg_reg
  import sdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             dpl_sel,
  output logic [2:0]       ras_code,
  output logic [1:0]       rp_code
);
  logic [REG_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)     store_q <= RESET_VAL;
    else if (we) store_q <= wdata & STORE_MASK;
  end

  assign rdata    = store_q;
  assign dpl_sel  = store_q[DPL_BIT];
  assign ras_code = store_q[RAS_LSB +: 3];
  assign rp_code  = store_q[RP_LSB +: 2];
endmodule

// File: rtl/sdg_gap_timer.sv
module sdg_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (start)             cnt_nx = len - CNT_W'(1);
    else if (cnt_q != '0)  cnt_nx = cnt_q - CNT_W'(1);
    else                   cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ready <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      ready <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/sdram_spacing_guard.sv
module sdram_spacing_guard
  import sdg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             act_req,
  output logic             act_ready,
  input  logic             wr_beat,
  input  logic             pre_req,
  output logic             pre_ready
);
  localparam int N_TIMERS = 3;
  localparam int T_RAS = 0;
  localparam int T_DPL = 1;
  localparam int T_RP  = 2;

  logic       dpl_sel;
  logic [2:0] ras_code;
  logic [1:0] rp_code;

  logic [N_TIMERS-1:0] start;
  logic [N_TIMERS-1:0] done;
  logic [CNT_W-1:0]    len [N_TIMERS];

  sdg_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .dpl_sel(dpl_sel), .ras_code(ras_code), .rp_code(rp_code)
  );

  // lengths come from the register as it stands before any write in this cycle
  assign start[T_RAS] = act_req & act_ready;
  assign start[T_DPL] = wr_beat;
  assign start[T_RP]  = pre_req & pre_ready;
  assign len[T_RAS]   = CNT_W'(ras_clocks(ras_code));
  assign len[T_DPL]   = CNT_W'(dpl_clocks(dpl_sel));
  assign len[T_RP]    = CNT_W'(rp_clocks(rp_code));

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
    sdg_gap_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .start(start[i]), .len(len[i]), .ready(done[i])
    );
  end

  assign act_ready = done[T_RP];
  assign pre_ready = done[T_RAS] & done[T_DPL];
endmodule

// File: rtl/sdram_spacing_guard_chk.sv
module sdram_spacing_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rdata,
  input logic        act_req,
  input logic        act_ready,
  input logic        wr_beat,
  input logic        pre_req,
  input logic        pre_ready
);
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_rdata == 32'h0000_0142 && act_ready && pre_ready));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~32'h0000_0173) == 32'h0);

  assert_ras_min_R4: assert property (@(posedge clk) disable iff (rst)
    (act_req && act_ready) |=> !pre_ready);

  assert_rp_min_R6: assert property (@(posedge clk) disable iff (rst)
    (pre_req && pre_ready) |=> !act_ready);

  assert_dpl_two_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_beat && cfg_rdata[8]) |=> !pre_ready);
endmodule

bind sdram_spacing_guard sdram_spacing_guard_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .act_req(act_req),
  .act_ready(act_ready), .wr_beat(wr_beat), .pre_req(pre_req),
  .pre_ready(pre_ready)
);

// File: tb/sdram_spacing_guard_tb.sv
module sdram_spacing_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        act_req = 1'b0, wr_beat = 1'b0, pre_req = 1'b0;
  logic        act_ready, pre_ready;

  sdram_spacing_guard u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .act_req(act_req), .act_ready(act_ready),
    .wr_beat(wr_beat), .pre_req(pre_req), .pre_ready(pre_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    compared = 0, mismatched = 0;
  int    exp_q[$];
  string tag_q[$];
  int    src = 0, tgt = 0, gap = 0, done_cnt = 0;
  bit    meas_on = 0, armed = 0;

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // monitor: counts clocks from the accepting edge until the dependent ready rises
  always @(negedge clk) begin : mon
    logic seen, tr;
    int   e;
    string t;
    seen = (src == 0) ? act_req : (src == 1) ? wr_beat : pre_req;
    tr   = (tgt == 0) ? pre_ready : act_ready;
    if (meas_on && !armed && seen) begin
      armed = 1; gap = 1;
    end else if (armed) begin
      gap++;
    end
    if (armed && tr) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (gap != e) begin
        mismatched++;
        $display("FAIL %s: spacing actual %0d expected %0d", t, gap, e);
      end
      armed = 0; meas_on = 0; done_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); #1; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); #1; cfg_we = 1'b0;
  endtask

  // s: 0 ACTIVE, 1 write beat, 2 PRECHARGE; t: 0 watch pre_ready, 1 watch act_ready
  task automatic measure(input int s, input int t, input int e, input string tag,
                         input bit mid_wr, input logic [31:0] mid_val);
    int d;
    d = done_cnt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while ((s == 0 && !act_ready) || (s == 2 && !pre_ready)) @(negedge clk);
    #1;
    src = s; tgt = t; meas_on = 1;
    if (s == 0) act_req = 1'b1; else if (s == 1) wr_beat = 1'b1; else pre_req = 1'b1;
    @(negedge clk); #1;
    act_req = 1'b0; wr_beat = 1'b0; pre_req = 1'b0;
    if (mid_wr) cfg_write(mid_val);
    wait (done_cnt != d);
    repeat (10) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL R10: watchdog expired, actual hung expected finished");
    summary_and_end();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset register", cfg_rdata, 32'h0000_0142);
    chk("R1 act_ready after reset", {31'b0, act_ready}, 32'd1);
    chk("R1 pre_ready after reset", {31'b0, pre_ready}, 32'd1);

    measure(0, 0, 8, "R4 R10 default active-to-precharge", 0, '0);
    measure(2, 1, 4, "R6 R10 default precharge-to-active", 0, '0);
    measure(1, 0, 2, "R3 R8 default write-to-precharge", 0, '0);

    cfg_write(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2 all ones masked", cfg_rdata, 32'h0000_0173);
    measure(0, 0, 8, "R5 reserved active code 7", 0, '0);
    measure(2, 1, 4, "R7 reserved precharge code 3", 0, '0);

    cfg_write(32'h0000_0050);
    measure(0, 0, 8, "R5 reserved active code 5", 0, '0);
    cfg_write(32'h0000_0060);
    measure(0, 0, 8, "R5 reserved active code 6", 0, '0);

    for (int c = 0; c <= 4; c++) begin
      cfg_write(32'(c) << 4);
      measure(0, 0, 4 + c, "R4 active code sweep", 0, '0);
    end
    measure(1, 0, 1, "R3 R8 write-to-precharge one clock", 0, '0);

    for (int p = 0; p <= 2; p++) begin
      cfg_write(32'(p));
      measure(2, 1, 2 + p, "R6 precharge code sweep", 0, '0);
    end

    cfg_write(32'h0000_0040);
    measure(0, 0, 8, "R9 running spacing keeps old length", 1, 32'h0000_0000);
    measure(0, 0, 4, "R9 next command uses new length", 0, '0);

    cfg_write(32'hFFFF_FE8C);
    @(negedge clk);
    chk("R2 reserved-only write reads zero", cfg_rdata, 32'h0);

    summary_and_end();
  end
endmodule